// File: doc/BRIEF.md
# ECC Error Logging Unit

This block records ECC error events from a memory path and from a system bus. It keeps them in two small logs that software can read. Each log holds two slots. A memory slot keeps the error type and, for uncorrectable errors, the DRAM row number. A row number is enough to point at a failing memory module. A bus slot keeps the error type, the syndrome and the data chunk index. Only the first errors are kept. Once both slots of a log are in use, later events of that kind are dropped, and the stored entries stay as they are.

The log storage is reset only by a power-on reset. The ordinary system reset leaves it alone, so software can inspect the cause of a failure after the machine comes back up. Software frees a slot by writing 1 to that slot's clear bit. The error indication pulses and the bus-error output keep working when a log is full. The bus-error output fires on an uncorrectable error only when the command-register enable is set.

Each log is a four-state machine whose state is the pair of slot valid bits:
- States: `LOG_EMPTY` (00), `LOG_LOW` (slot 0 only), `LOG_HIGH` (slot 1 only) and `LOG_FULL` (both).
- Software clears act first and give a "held" state.
- An event then takes one of three transitions:
  - `LOG_EMPTY` or `LOG_HIGH` go to slot 0 (fill-low).
  - `LOG_LOW` goes to slot 1 (fill-high).
  - `LOG_FULL` drops the event.

Top module: `ecc_errlog`

## Requirements
- R1: The first two memory error events are logged. Once both memory slots are valid, further memory events change no memory slot contents or valid bits.
- R2: A memory slot stores a type bit (1 = multi-bit uncorrectable, 0 = single-bit). It stores the row number for a multi-bit error, and all-zero row for a single-bit error.
- R3: A bus slot stores the type bit (1 = multi-bit), syndrome and chunk index of each of the first two bus error events, of either type.
- R4: Valid bits and slot contents are cleared only by `por_n` low. While `sys_rst_n` is low they do not change, and events and clears are ignored.
- R5: `berr_out` is high for the one cycle after a clock edge that samples a multi-bit event from either source. It fires only when `berr_en` was 1 at that edge.
- R6: `err_ind[0]` (correctable) and `err_ind[1]` (uncorrectable) pulse for one cycle after the edge that samples the matching event, from either source, whether or not a log is full.
- R7: Writing 1 to a clear bit invalidates that slot at the next edge. The next event fills the lowest-numbered free slot, so slot 0 fills before slot 1.
- R8: If an event arrives in the same cycle as a clear of the slot it would target, the event is logged and the slot stays valid.
- R9: `mem_full` and `bus_full` are 1 exactly when both slots of their log are valid.
- R10: While `sys_rst_n` is low, `err_ind` and `berr_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the logs |
| sys_rst_n | input | 1 | System reset, active low, resets signaling only |
| berr_en | input | 1 | Command enable for the bus-error output |
| mem_err_vld | input | 1 | Memory error event strobe |
| mem_err_multi | input | 1 | Memory event is multi-bit |
| mem_err_row | input | ROW_W | DRAM row of the memory event |
| bus_err_vld | input | 1 | Bus error event strobe |
| bus_err_multi | input | 1 | Bus event is multi-bit |
| bus_err_syn | input | SYN_W | Bus event syndrome |
| bus_err_chunk | input | CHK_W | Bus event chunk index |
| mem_clr | input | 2 | Per-slot write-1 clear, memory log |
| bus_clr | input | 2 | Per-slot write-1 clear, bus log |
| mem_log_vld | output | 2 | Memory slot valid bits |
| mem_log_multi | output | 2 | Memory slot type bits |
| mem_log_row0 | output | ROW_W | Memory slot 0 row |
| mem_log_row1 | output | ROW_W | Memory slot 1 row |
| mem_full | output | 1 | Both memory slots valid |
| bus_log_vld | output | 2 | Bus slot valid bits |
| bus_log_multi | output | 2 | Bus slot type bits |
| bus_log_syn0 | output | SYN_W | Bus slot 0 syndrome |
| bus_log_syn1 | output | SYN_W | Bus slot 1 syndrome |
| bus_log_chunk0 | output | CHK_W | Bus slot 0 chunk |
| bus_log_chunk1 | output | CHK_W | Bus slot 1 chunk |
| bus_full | output | 1 | Both bus slots valid |
| err_ind | output | 2 | Error pulses: bit 0 correctable, bit 1 uncorrectable |
| berr_out | output | 1 | Bus-error pulse for enabled uncorrectable errors |

## Verification
The hardest situation to reach is the `LOG_HIGH` state, where slot 1 holds an entry while slot 0 is free. A related hard case is a clear and an event landing in the same cycle. Neither can happen without software intervening between error events. The stimulus table reaches them in order:
1. Fill the memory log.
2. Clear only slot 0, which reaches `LOG_HIGH`.
3. Send an event, which must refill slot 0.
4. Clear slot 1 in the same cycle as a new event, which must be logged there.

Directed steps then hold the system reset low while events and clears are driven. This shows the logs are sticky and that signaling stays quiet.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int NSLOT = 2;

    // State of a two-slot log; the encoding is the slot valid vector.
    typedef enum logic [1:0] {
        LOG_EMPTY = 2'b00,
        LOG_LOW   = 2'b01,
        LOG_HIGH  = 2'b10,
        LOG_FULL  = 2'b11
    } log_state_e;

endpackage

// File: rtl/errlog_bank.sv
module errlog_bank
    import errlog_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic             ev,
    input  logic [PAY_W-1:0] pay_in,
    input  logic [1:0]       clr,
    output logic [1:0]       vld,
    output logic             full,
    output logic [PAY_W-1:0] pay0,
    output logic [PAY_W-1:0] pay1
);

    log_state_e       state_q;
    log_state_e       held_st;
    log_state_e       nxt_st;
    logic [1:0]       clr_eff;
    logic             ev_eff;
    logic [1:0]       wr;
    logic [PAY_W-1:0] pay_q [NSLOT];

    // Clears apply first; the event then targets the lowest free slot.
    always_comb begin
        clr_eff = run ? clr : 2'b00;
        ev_eff  = run & ev;
        held_st = log_state_e'(state_q & ~clr_eff);
        wr      = 2'b00;
        unique case (held_st)
            LOG_EMPTY: if (ev_eff) wr = 2'b01;   // fill-low
            LOG_LOW:   if (ev_eff) wr = 2'b10;   // fill-high
            LOG_HIGH:  if (ev_eff) wr = 2'b01;   // fill-low into the hole
            LOG_FULL:  wr = 2'b00;               // drop
        endcase
        nxt_st = log_state_e'(held_st | wr);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= LOG_EMPTY;
        else        state_q <= nxt_st;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)     pay_q[g] <= '0;
            else if (wr[g]) pay_q[g] <= pay_in;
        end
    end

    always_comb begin
        vld  = state_q;
        full = (state_q == LOG_FULL);
        pay0 = pay_q[0];
        pay1 = pay_q[1];
    end

endmodule

// File: rtl/errlog_signal.sv
module errlog_signal (
    input  logic       clk,
    input  logic       sys_rst_n,
    input  logic       berr_en,
    input  logic       mem_ev,
    input  logic       mem_multi,
    input  logic       bus_ev,
    input  logic       bus_multi,
    output logic [1:0] err_ind,
    output logic       berr
);

    logic corr_d;
    logic fatal_d;

    always_comb begin
        corr_d  = (mem_ev & ~mem_multi) | (bus_ev & ~bus_multi);
        fatal_d = (mem_ev &  mem_multi) | (bus_ev &  bus_multi);
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            err_ind <= 2'b00;
            berr    <= 1'b0;
        end else begin
            err_ind <= {fatal_d, corr_d};
            berr    <= fatal_d & berr_en;
        end
    end

endmodule

// File: rtl/ecc_errlog.sv
module ecc_errlog #(
    parameter int ROW_W = 14,
    parameter int SYN_W = 8,
    parameter int CHK_W = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             berr_en,
    input  logic             mem_err_vld,
    input  logic             mem_err_multi,
    input  logic [ROW_W-1:0] mem_err_row,
    input  logic             bus_err_vld,
    input  logic             bus_err_multi,
    input  logic [SYN_W-1:0] bus_err_syn,
    input  logic [CHK_W-1:0] bus_err_chunk,
    input  logic [1:0]       mem_clr,
    input  logic [1:0]       bus_clr,
    output logic [1:0]       mem_log_vld,
    output logic [1:0]       mem_log_multi,
    output logic [ROW_W-1:0] mem_log_row0,
    output logic [ROW_W-1:0] mem_log_row1,
    output logic             mem_full,
    output logic [1:0]       bus_log_vld,
    output logic [1:0]       bus_log_multi,
    output logic [SYN_W-1:0] bus_log_syn0,
    output logic [SYN_W-1:0] bus_log_syn1,
    output logic [CHK_W-1:0] bus_log_chunk0,
    output logic [CHK_W-1:0] bus_log_chunk1,
    output logic             bus_full,
    output logic [1:0]       err_ind,
    output logic             berr_out
);

    localparam int MPAY_W = ROW_W + 1;
    localparam int BPAY_W = SYN_W + CHK_W + 1;

    logic [MPAY_W-1:0] mem_pay_in;
    logic [MPAY_W-1:0] mem_pay0;
    logic [MPAY_W-1:0] mem_pay1;
    logic [BPAY_W-1:0] bus_pay_in;
    logic [BPAY_W-1:0] bus_pay0;
    logic [BPAY_W-1:0] bus_pay1;

    // Row is only meaningful for uncorrectable memory errors.
    always_comb begin
        mem_pay_in = {mem_err_multi, mem_err_multi ? mem_err_row : {ROW_W{1'b0}}};
        bus_pay_in = {bus_err_multi, bus_err_syn, bus_err_chunk};
    end

    errlog_bank #(.PAY_W(MPAY_W)) u_mem_bank (
        .clk    (clk),
        .por_n  (por_n),
        .run    (sys_rst_n),
        .ev     (mem_err_vld),
        .pay_in (mem_pay_in),
        .clr    (mem_clr),
        .vld    (mem_log_vld),
        .full   (mem_full),
        .pay0   (mem_pay0),
        .pay1   (mem_pay1)
    );

    errlog_bank #(.PAY_W(BPAY_W)) u_bus_bank (
        .clk    (clk),
        .por_n  (por_n),
        .run    (sys_rst_n),
        .ev     (bus_err_vld),
        .pay_in (bus_pay_in),
        .clr    (bus_clr),
        .vld    (bus_log_vld),
        .full   (bus_full),
        .pay0   (bus_pay0),
        .pay1   (bus_pay1)
    );

    errlog_signal u_signal (
        .clk       (clk),
        .sys_rst_n (sys_rst_n),
        .berr_en   (berr_en),
        .mem_ev    (mem_err_vld),
        .mem_multi (mem_err_multi),
        .bus_ev    (bus_err_vld),
        .bus_multi (bus_err_multi),
        .err_ind   (err_ind),
        .berr      (berr_out)
    );

    always_comb begin
        mem_log_multi  = {mem_pay1[MPAY_W-1], mem_pay0[MPAY_W-1]};
        mem_log_row0   = mem_pay0[ROW_W-1:0];
        mem_log_row1   = mem_pay1[ROW_W-1:0];
        bus_log_multi  = {bus_pay1[BPAY_W-1], bus_pay0[BPAY_W-1]};
        bus_log_syn0   = bus_pay0[CHK_W +: SYN_W];
        bus_log_syn1   = bus_pay1[CHK_W +: SYN_W];
        bus_log_chunk0 = bus_pay0[CHK_W-1:0];
        bus_log_chunk1 = bus_pay1[CHK_W-1:0];
    end

endmodule

// File: rtl/errlog_chk.sv
module errlog_chk #(
    parameter int ROW_W = 14
) (
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             berr_en,
    input logic             mem_err_vld,
    input logic             mem_err_multi,
    input logic [1:0]       mem_clr,
    input logic [1:0]       mem_log_vld,
    input logic [ROW_W-1:0] mem_log_row0,
    input logic [ROW_W-1:0] mem_log_row1,
    input logic             mem_full,
    input logic [1:0]       bus_log_vld,
    input logic             bus_full,
    input logic [1:0]       err_ind,
    input logic             berr_out
);

    // R5: the bus-error pulse needs the enable at the sampling edge
    assert_berr_enabled_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        berr_out |-> $past(berr_en));

    // R6: a sampled correctable memory event produces the correctable pulse
    assert_corr_pulse_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (mem_err_vld && !mem_err_multi) |=> err_ind[0]);

    // R1: a full memory log with no clear keeps its rows
    assert_full_holds_R1: assert property (@(posedge clk) disable iff (!por_n)
        (mem_full && mem_clr == 2'b00) |=> ($stable(mem_log_row0) && $stable(mem_log_row1)));

    // R7: slot 1 only becomes valid while slot 0 is valid
    assert_mem_order_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mem_log_vld[1]) |-> mem_log_vld[0]);

    assert_bus_order_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(bus_log_vld[1]) |-> bus_log_vld[0]);

    // R4: system reset freezes both logs
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
        $past(!sys_rst_n) |-> ($stable(mem_log_vld) && $stable(bus_log_vld)));

    // R9: full flags agree with the valid bits
    assert_full_flag_R9: assert property (@(posedge clk) disable iff (!por_n)
        (mem_full == (mem_log_vld == 2'b11)) && (bus_full == (bus_log_vld == 2'b11)));

endmodule

bind ecc_errlog errlog_chk #(.ROW_W(ROW_W)) u_errlog_chk (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rst_n    (sys_rst_n),
    .berr_en      (berr_en),
    .mem_err_vld  (mem_err_vld),
    .mem_err_multi(mem_err_multi),
    .mem_clr      (mem_clr),
    .mem_log_vld  (mem_log_vld),
    .mem_log_row0 (mem_log_row0),
    .mem_log_row1 (mem_log_row1),
    .mem_full     (mem_full),
    .bus_log_vld  (bus_log_vld),
    .bus_full     (bus_full),
    .err_ind      (err_ind),
    .berr_out     (berr_out)
);

// File: tb/ecc_errlog_bench.sv
module ecc_errlog_bench;

    localparam int ROW_W = 14;
    localparam int SYN_W = 8;
    localparam int CHK_W = 3;
    localparam int NVEC  = 10;

    // {mev,mmul,bev,bmul,en, mclr[2], bclr[2], x_mvld[2], x_bvld[2], x_err[2], x_berr}
    localparam logic [15:0] TBL [NVEC] = '{
        16'b10001_00_00_01_00_01_0,  // R1 first memory entry, correctable
        16'b11001_00_00_11_00_10_1,  // R5 fatal with enable
        16'b11000_00_00_11_00_10_0,  // R1 dropped when full, R5 enable low
        16'b00100_00_00_11_01_01_0,  // R3 bus single
        16'b00111_00_00_11_11_10_1,  // R3 bus multi
        16'b00000_01_00_10_11_00_0,  // R7 clear slot 0 -> LOG_HIGH
        16'b10000_00_00_11_11_01_0,  // R7 refill slot 0
        16'b11001_10_00_11_11_10_1,  // R8 clear and event same cycle
        16'b00000_00_11_11_00_00_0,  // R7 clear bus log
        16'b10110_00_00_11_01_11_0   // R6 pulses while memory log full
    };

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             sys_rst_n = 1'b0;
    logic             berr_en = 1'b0;
    logic             mem_err_vld = 1'b0;
    logic             mem_err_multi = 1'b0;
    logic [ROW_W-1:0] mem_err_row = '0;
    logic             bus_err_vld = 1'b0;
    logic             bus_err_multi = 1'b0;
    logic [SYN_W-1:0] bus_err_syn = '0;
    logic [CHK_W-1:0] bus_err_chunk = '0;
    logic [1:0]       mem_clr = 2'b00;
    logic [1:0]       bus_clr = 2'b00;
    logic [1:0]       mem_log_vld, mem_log_multi, bus_log_vld, bus_log_multi, err_ind;
    logic [ROW_W-1:0] mem_log_row0, mem_log_row1;
    logic [SYN_W-1:0] bus_log_syn0, bus_log_syn1;
    logic [CHK_W-1:0] bus_log_chunk0, bus_log_chunk1;
    logic             mem_full, bus_full, berr_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    ecc_errlog #(.ROW_W(ROW_W), .SYN_W(SYN_W), .CHK_W(CHK_W)) u_ecc_errlog (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .berr_en(berr_en),
        .mem_err_vld(mem_err_vld), .mem_err_multi(mem_err_multi), .mem_err_row(mem_err_row),
        .bus_err_vld(bus_err_vld), .bus_err_multi(bus_err_multi), .bus_err_syn(bus_err_syn),
        .bus_err_chunk(bus_err_chunk), .mem_clr(mem_clr), .bus_clr(bus_clr),
        .mem_log_vld(mem_log_vld), .mem_log_multi(mem_log_multi),
        .mem_log_row0(mem_log_row0), .mem_log_row1(mem_log_row1), .mem_full(mem_full),
        .bus_log_vld(bus_log_vld), .bus_log_multi(bus_log_multi),
        .bus_log_syn0(bus_log_syn0), .bus_log_syn1(bus_log_syn1),
        .bus_log_chunk0(bus_log_chunk0), .bus_log_chunk1(bus_log_chunk1),
        .bus_full(bus_full), .err_ind(err_ind), .berr_out(berr_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        mem_err_vld = 1'b0; bus_err_vld = 1'b0; mem_clr = 2'b00; bus_clr = 2'b00;
    endtask

    // one event/clear cycle: drive at negedge, sample after the edge
    task automatic step(input logic mev, input logic mmul, input logic [ROW_W-1:0] row,
                        input logic bev, input logic bmul, input logic [SYN_W-1:0] syn,
                        input logic [CHK_W-1:0] chunk, input logic en,
                        input logic [1:0] mc, input logic [1:0] bc);
        @(negedge clk);
        mem_err_vld = mev; mem_err_multi = mmul; mem_err_row = row;
        bus_err_vld = bev; bus_err_multi = bmul; bus_err_syn = syn; bus_err_chunk = chunk;
        berr_en = en; mem_clr = mc; bus_clr = bc;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); por_n = 1'b1; sys_rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R4 reset mem vld", mem_log_vld, 2'b00);
        chk("R4 reset bus vld", bus_log_vld, 2'b00);
        chk("R9 reset full", {mem_full, bus_full}, 2'b00);
        chk("R10 reset err", {err_ind, berr_out}, 3'b000);

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            v = TBL[i];
            step(v[15], v[14], ROW_W'(i * 3 + 1), v[13], v[12], SYN_W'(i + 5),
                 CHK_W'(i), v[11], v[10:9], v[8:7]);
            chk($sformatf("R1/R7 vec%0d mem vld", i), mem_log_vld, v[6:5]);
            chk($sformatf("R3/R8 vec%0d bus vld", i), bus_log_vld, v[4:3]);
            chk($sformatf("R6 vec%0d err_ind", i), err_ind, v[2:1]);
            chk($sformatf("R5 vec%0d berr", i), berr_out, v[0]);
            chk($sformatf("R9 vec%0d full", i), {mem_full, bus_full},
                {v[6:5] == 2'b11, v[4:3] == 2'b11});
        end

        // clear everything
        step(0, 0, '0, 0, 0, '0, '0, 0, 2'b11, 2'b11);
        chk("R7 mem cleared", mem_log_vld, 2'b00);
        chk("R9 full cleared", {mem_full, bus_full}, 2'b00);

        // R2 memory payloads
        step(1, 1, 14'h2A5, 0, 0, '0, '0, 0, 2'b00, 2'b00);
        chk("R2 row0", mem_log_row0, 14'h2A5);
        chk("R5 berr disabled", berr_out, 1'b0);
        chk("R6 fatal pulse", err_ind, 2'b10);
        step(1, 0, 14'h111, 0, 0, '0, '0, 0, 2'b00, 2'b00);
        chk("R2 row1 zero for single", mem_log_row1, 14'h0);
        chk("R2 type bits", mem_log_multi, 2'b01);
        step(1, 1, 14'h3FF, 0, 0, '0, '0, 1, 2'b00, 2'b00);
        chk("R1 row0 kept", mem_log_row0, 14'h2A5);
        chk("R1 row1 kept", mem_log_row1, 14'h0);
        chk("R1 type kept", mem_log_multi, 2'b01);
        chk("R5 berr still fires when full", berr_out, 1'b1);

        // R3 bus payloads
        step(0, 0, '0, 1, 0, 8'h5C, 3'd2, 0, 2'b00, 2'b00);
        step(0, 0, '0, 1, 1, 8'hA3, 3'd5, 0, 2'b00, 2'b00);
        chk("R3 syn0", bus_log_syn0, 8'h5C);
        chk("R3 chunk0", bus_log_chunk0, 3'd2);
        chk("R3 syn1", bus_log_syn1, 8'hA3);
        chk("R3 chunk1", bus_log_chunk1, 3'd5);
        chk("R3 types", bus_log_multi, 2'b10);

        // R4/R10 system reset leaves logs and ignores stimulus
        @(negedge clk);
        sys_rst_n = 1'b0;
        mem_err_vld = 1'b1; mem_err_multi = 1'b1; mem_err_row = 14'h0F0;
        bus_err_vld = 1'b1; mem_clr = 2'b11; bus_clr = 2'b11; berr_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R4 mem vld sticky", mem_log_vld, 2'b11);
        chk("R4 bus vld sticky", bus_log_vld, 2'b11);
        chk("R4 row0 sticky", mem_log_row0, 14'h2A5);
        chk("R10 quiet in reset", {err_ind, berr_out}, 3'b000);
        @(negedge clk); idle(); sys_rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R4 syn1 after reset", bus_log_syn1, 8'hA3);

        // R4 power-on reset clears the logs
        @(negedge clk); por_n = 1'b0;
        @(posedge clk); #1;
        chk("R4 por clears mem", mem_log_vld, 2'b00);
        chk("R4 por clears row", mem_log_row0, 14'h0);
        chk("R4 por clears bus", bus_log_vld, 2'b00);
        @(negedge clk); por_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule